// File: doc/BRIEF.md
# Graphics-Over-Text Video Compositor

This block produces the final 3-bit RGB value for every screen pixel by combining three sources: the colour coming from the text generator, a pixel read from an 8-colour graphics framebuffer, and a fixed border colour used wherever the beam is outside the displayed image. Each colour is three bits with green in bit 2, red in bit 1 and blue in bit 0, and the same layout applies to text, graphics and border.

Two byte-wide registers written through an I/O port interface control it. A mode register turns the graphics layer on, picks the graphics resolution (640×200, or 320×200 with each stored pixel repeated over two screen pixels), and picks how the layers merge: either graphics drawn over the text with black graphics pixels letting the text show through, or graphics alone with the text hidden. A border register holds the colour shown outside the image. Writes land in holding copies at once and are read back from there, but the compositor only adopts them on the next frame-start pulse, so the picture never changes part way down a frame.

The block forms the framebuffer read address from the pixel counters and registers it one cycle before the pixel is composed, so a framebuffer that answers within that cycle delivers data aligned with the delayed text colour and area flag.

Top module: `gfx_compositor`

## Requirements
- R1: After reset both registers read back 0, which means graphics off, 640×200, overlay blend and a black border; outside the image the output is then 000.
- R2: A write to port 0xF9 stores data bits 5:0 (read back with bits 7:6 as 0); a write to port 0xF3 stores data bits 2:0 (read back with bits 7:3 as 0); reading any other port returns 0 and writing any other port changes neither register.
- R3: A register write is visible on read-back on the next cycle but changes the picture only after the next frameStart pulse; until then the previous settings remain in force.
- R4: When the image-area flag is low, the output equals the border colour (border register bits 2:0).
- R5: When mode bit 2 is 0 and the image-area flag is high, the output equals the text colour.
- R6: With mode bit 2 set and mode bit 4 clear, a non-zero graphics pixel replaces the text colour and a graphics pixel of 000 leaves the text colour visible.
- R7: With mode bits 2 and 4 set, the output equals the graphics pixel, including 000, and the text colour is ignored.
- R8: With mode bit 3 clear the framebuffer address is y×640 + x.
- R9: With mode bit 3 set the framebuffer address is y×320 + floor(x/2), so screen pixels 2k and 2k+1 of a line read the same stored pixel.
- R10: The framebuffer address appears one cycle after the pixel counters; the framebuffer data is taken in the following cycle, and the output appears two cycles after the pixel counters, text colour and area flag.
- R11: Mode bits 1:0 and 5 have no effect on the address or the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ioWrEn | input | 1 | I/O write strobe, one cycle per write |
| ioAddr | input | 8 | I/O port number for reads and writes |
| ioWrData | input | 8 | I/O write data |
| ioRdData | output | 8 | Read-back of the addressed register, combinational |
| frameStart | input | 1 | One-cycle pulse at the start of each frame |
| imgActive | input | 1 | High while the pixel lies inside the image area |
| pixX | input | 10 | Horizontal pixel counter, 0 to 639 |
| pixY | input | 8 | Vertical pixel counter, 0 to 199 |
| textRgb | input | 3 | Text-layer colour for this pixel |
| fbRdAddr | output | 17 | Framebuffer read address |
| fbRdData | input | 3 | Framebuffer pixel returned for fbRdAddr |
| rgbOut | output | 3 | Final pixel colour |

## Verification
A corrupted active setting shows up as a wrong colour or wrong address on the very next pixel after the frame start that loaded it, and stays wrong for the whole frame, while a fault in the holding copies shows at once on read-back but only reaches the picture after a frame pulse. A slip in the pipeline shows as an address or colour belonging to the neighbouring pixel, so checks sample the address exactly one cycle and the colour exactly two cycles after the inputs. Pairing each colour check with a framebuffer that returns a decoy value for any other address lets a wrong address surface as a wrong colour too.

// File: rtl/gfx_compositor_pkg.sv
package gfx_compositor_pkg;

  localparam int CW = 3;

  // settings in force for the current frame, handed from control to datapath
  typedef struct packed {
    logic          gfxEn;
    logic          lowRes;
    logic          gfxOnly;
    logic [CW-1:0] border;
  } ctrlBus_t;

endpackage

// File: rtl/gfx_compositor_ctrl.sv
module gfx_compositor_ctrl
  import gfx_compositor_pkg::*;
#(
  parameter logic [7:0] MODE_PORT   = 8'hF9,
  parameter logic [7:0] BORDER_PORT = 8'hF3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ioWrEn,
  input  logic [7:0] ioAddr,
  input  logic [7:0] ioWrData,
  output logic [7:0] ioRdData,
  input  logic       frameStart,
  output ctrlBus_t   ctrlBus
);

  localparam int MODE_BITS = 6;

  logic [MODE_BITS-1:0] pendMode;
  logic [CW-1:0]        pendBorder;
  ctrlBus_t             liveBus;
  logic                 unusedWrBits;

  assign unusedWrBits = ^ioWrData[7:MODE_BITS];

  // holding copies, written straight from the port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendMode   <= '0;
      pendBorder <= '0;
    end else if (ioWrEn) begin
      if (ioAddr == MODE_PORT)   pendMode   <= ioWrData[MODE_BITS-1:0];
      if (ioAddr == BORDER_PORT) pendBorder <= ioWrData[CW-1:0];
    end
  end

  // copies in force, adopted only at a frame boundary
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      liveBus <= '0;
    end else if (frameStart) begin
      liveBus.gfxEn   <= pendMode[2];
      liveBus.lowRes  <= pendMode[3];
      liveBus.gfxOnly <= pendMode[4];
      liveBus.border  <= pendBorder;
    end
  end

  always_comb begin
    ioRdData = '0;
    if (ioAddr == MODE_PORT)        ioRdData = {{(8-MODE_BITS){1'b0}}, pendMode};
    else if (ioAddr == BORDER_PORT) ioRdData = {{(8-CW){1'b0}}, pendBorder};
  end

  assign ctrlBus = liveBus;

endmodule

// File: rtl/gfx_compositor_dp.sv
module gfx_compositor_dp
  import gfx_compositor_pkg::*;
#(
  parameter int HRES = 640,
  parameter int VRES = 200,
  localparam int XW = $clog2(HRES),
  localparam int YW = $clog2(VRES),
  localparam int AW = $clog2(HRES * VRES)
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlBus_t      ctrlBus,
  input  logic          imgActive,
  input  logic [XW-1:0] pixX,
  input  logic [YW-1:0] pixY,
  input  logic [CW-1:0] textRgb,
  output logic [AW-1:0] fbRdAddr,
  input  logic [CW-1:0] fbRdData,
  output logic [CW-1:0] rgbOut
);

  localparam logic [AW-1:0] ROW_FULL = AW'(HRES);
  localparam logic [AW-1:0] ROW_HALF = AW'(HRES / 2);

  logic [AW-1:0] rowWidth;
  logic [AW-1:0] colIdx;
  logic [AW-1:0] nextAddr;
  logic          activeD;
  logic [CW-1:0] textD;
  logic [CW-1:0] mixed;

  // address for the pixel presented this cycle
  always_comb begin
    rowWidth = ctrlBus.lowRes ? ROW_HALF : ROW_FULL;
    colIdx   = ctrlBus.lowRes ? AW'(pixX >> 1) : AW'(pixX);
    nextAddr = AW'(pixY) * rowWidth + colIdx;
  end

  // stage 1: issue address, delay text colour and area flag to match
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fbRdAddr <= '0;
      activeD  <= 1'b0;
      textD    <= '0;
    end else begin
      fbRdAddr <= nextAddr;
      activeD  <= imgActive;
      textD    <= textRgb;
    end
  end

  // layer merge
  always_comb begin
    if (!activeD)                           mixed = ctrlBus.border;
    else if (!ctrlBus.gfxEn)                mixed = textD;
    else if (ctrlBus.gfxOnly)               mixed = fbRdData;
    else if (fbRdData != '0)                mixed = fbRdData;
    else                                    mixed = textD;
  end

  // stage 2: final pixel
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rgbOut <= '0;
    else       rgbOut <= mixed;
  end

endmodule

// File: rtl/gfx_compositor.sv
module gfx_compositor
  import gfx_compositor_pkg::*;
#(
  parameter int         HRES        = 640,
  parameter int         VRES        = 200,
  parameter logic [7:0] MODE_PORT   = 8'hF9,
  parameter logic [7:0] BORDER_PORT = 8'hF3,
  localparam int XW = $clog2(HRES),
  localparam int YW = $clog2(VRES),
  localparam int AW = $clog2(HRES * VRES)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ioWrEn,
  input  logic [7:0]    ioAddr,
  input  logic [7:0]    ioWrData,
  output logic [7:0]    ioRdData,
  input  logic          frameStart,
  input  logic          imgActive,
  input  logic [XW-1:0] pixX,
  input  logic [YW-1:0] pixY,
  input  logic [CW-1:0] textRgb,
  output logic [AW-1:0] fbRdAddr,
  input  logic [CW-1:0] fbRdData,
  output logic [CW-1:0] rgbOut
);

  ctrlBus_t ctrlBus;

  gfx_compositor_ctrl #(
    .MODE_PORT  (MODE_PORT),
    .BORDER_PORT(BORDER_PORT)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .ioWrEn    (ioWrEn),
    .ioAddr    (ioAddr),
    .ioWrData  (ioWrData),
    .ioRdData  (ioRdData),
    .frameStart(frameStart),
    .ctrlBus   (ctrlBus)
  );

  gfx_compositor_dp #(
    .HRES(HRES),
    .VRES(VRES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlBus  (ctrlBus),
    .imgActive(imgActive),
    .pixX     (pixX),
    .pixY     (pixY),
    .textRgb  (textRgb),
    .fbRdAddr (fbRdAddr),
    .fbRdData (fbRdData),
    .rgbOut   (rgbOut)
  );

endmodule

// File: rtl/gfx_compositor_chk.sv
module gfx_compositor_chk
  import gfx_compositor_pkg::*;
(
  input logic          clk,
  input logic          rstN,
  input logic          frameStart,
  input logic          imgActive,
  input logic [CW-1:0] textRgb,
  input logic [CW-1:0] fbRdData,
  input logic [CW-1:0] rgbOut,
  input ctrlBus_t      cb
);

  logic [1:0] warm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  // R3: settings in force change only on the edge after a frame pulse
  a_r3_frame_hold: assert property (@(posedge clk) disable iff (!rstN)
    (warm != 2'd0 && !$past(frameStart)) |-> $stable(cb));

  // R4: outside the image the border colour is shown
  a_r4_border_fill: assert property (@(posedge clk) disable iff (!rstN)
    (warm == 2'd3 && !$past(imgActive, 2)) |-> rgbOut == $past(cb.border));

  // R5: graphics off passes text through
  a_r5_text_only: assert property (@(posedge clk) disable iff (!rstN)
    (warm == 2'd3 && $past(imgActive, 2) && !$past(cb.gfxEn))
      |-> rgbOut == $past(textRgb, 2));

  // R6: black graphics pixel is see-through in overlay
  a_r6_transparent: assert property (@(posedge clk) disable iff (!rstN)
    (warm == 2'd3 && $past(imgActive, 2) && $past(cb.gfxEn) && !$past(cb.gfxOnly)
      && $past(fbRdData) == '0) |-> rgbOut == $past(textRgb, 2));

  // R7: graphics-only shows the framebuffer pixel
  a_r7_gfx_only: assert property (@(posedge clk) disable iff (!rstN)
    (warm == 2'd3 && $past(imgActive, 2) && $past(cb.gfxEn) && $past(cb.gfxOnly))
      |-> rgbOut == $past(fbRdData));

endmodule

bind gfx_compositor gfx_compositor_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .frameStart(frameStart),
  .imgActive (imgActive),
  .textRgb   (textRgb),
  .fbRdData  (fbRdData),
  .rgbOut    (rgbOut),
  .cb        (ctrlBus)
);

// File: tb/gfx_compositor_test.sv
module gfx_compositor_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ioWrEn = 1'b0;
  logic [7:0]  ioAddr = 8'h00;
  logic [7:0]  ioWrData = 8'h00;
  logic [7:0]  ioRdData;
  logic        frameStart = 1'b0;
  logic        imgActive = 1'b0;
  logic [9:0]  pixX = '0;
  logic [7:0]  pixY = '0;
  logic [2:0]  textRgb = '0;
  logic [16:0] fbRdAddr;
  logic [2:0]  fbRdData;
  logic [2:0]  rgbOut;

  // framebuffer model: the wanted pixel at the wanted address, a decoy elsewhere
  logic [16:0] wantAddr = '0;
  logic [2:0]  wantPix = '0;
  assign fbRdData = (fbRdAddr == wantAddr) ? wantPix : 3'b101;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gfx_compositor uut (
    .clk(clk), .rstN(rstN), .ioWrEn(ioWrEn), .ioAddr(ioAddr),
    .ioWrData(ioWrData), .ioRdData(ioRdData), .frameStart(frameStart),
    .imgActive(imgActive), .pixX(pixX), .pixY(pixY), .textRgb(textRgb),
    .fbRdAddr(fbRdAddr), .fbRdData(fbRdData), .rgbOut(rgbOut)
  );

  typedef struct packed {
    logic [7:0]  mode;
    logic [2:0]  border;
    logic        act;
    logic [2:0]  text;
    logic [2:0]  gfx;
    logic [9:0]  x;
    logic [7:0]  y;
    logic [16:0] addr;
    logic [2:0]  rgb;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 3'd5, 1'b0, 3'd3, 3'd6, 10'd10,  8'd5,   17'd3210,   3'd5}, // R4
    '{8'h00, 3'd0, 1'b1, 3'd3, 3'd6, 10'd0,   8'd0,   17'd0,      3'd3}, // R5
    '{8'h04, 3'd1, 1'b1, 3'd2, 3'd6, 10'd639, 8'd199, 17'd127999, 3'd6}, // R6 R8
    '{8'h04, 3'd1, 1'b1, 3'd2, 3'd0, 10'd1,   8'd1,   17'd641,    3'd2}, // R6
    '{8'h14, 3'd1, 1'b1, 3'd7, 3'd0, 10'd100, 8'd2,   17'd1380,   3'd0}, // R7
    '{8'h14, 3'd1, 1'b1, 3'd7, 3'd3, 10'd3,   8'd0,   17'd3,      3'd3}, // R7
    '{8'h0C, 3'd0, 1'b1, 3'd1, 3'd4, 10'd101, 8'd3,   17'd1010,   3'd4}, // R9
    '{8'h0C, 3'd0, 1'b1, 3'd1, 3'd0, 10'd100, 8'd3,   17'd1010,   3'd1}, // R9
    '{8'h2F, 3'd0, 1'b1, 3'd6, 3'd2, 10'd639, 8'd199, 17'd63999,  3'd2}, // R11 R9
    '{8'h27, 3'd0, 1'b1, 3'd4, 3'd1, 10'd5,   8'd0,   17'd5,      3'd1}, // R11
    '{8'h1C, 3'd7, 1'b0, 3'd2, 3'd3, 10'd0,   8'd0,   17'd0,      3'd7}  // R4
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ioWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    ioWrEn = 1'b1; ioAddr = a; ioWrData = d;
    @(negedge clk);
    ioWrEn = 1'b0;
  endtask

  task automatic ioRead(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    ioAddr = a;
    #1 d = ioRdData;
  endtask

  task automatic pulseFrame();
    @(negedge clk);
    frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
  endtask

  // present a pixel, check address after one edge and colour after two (R10)
  task automatic runPixel(input string req, input logic act, input logic [2:0] txt,
                          input logic [2:0] g, input logic [9:0] x, input logic [7:0] y,
                          input logic [16:0] expAddr, input logic [2:0] expRgb);
    @(negedge clk);
    imgActive = act; textRgb = txt; pixX = x; pixY = y;
    wantAddr = expAddr; wantPix = g;
    @(negedge clk);
    check({req, " R10 addr"}, 32'(fbRdAddr), 32'(expAddr));
    @(negedge clk);
    check({req, " R10 rgb"}, 32'(rgbOut), 32'(expRgb));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rgb", 32'(rgbOut), 32'd0);
    check("R1 addr", 32'(fbRdAddr), 32'd0);
    rstN = 1'b1;
    ioRead(8'hF9, rd); check("R1 mode", 32'(rd), 32'h00);
    ioRead(8'hF3, rd); check("R1 border", 32'(rd), 32'h00);
    runPixel("R1 dark border", 1'b0, 3'd6, 3'd2, 10'd0, 8'd0, 17'd0, 3'd0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      ioWrite(8'hF9, VECS[i].mode);
      ioWrite(8'hF3, {5'b0, VECS[i].border});
      pulseFrame();
      runPixel($sformatf("vec%0d R4-R9", i), VECS[i].act, VECS[i].text, VECS[i].gfx,
               VECS[i].x, VECS[i].y, VECS[i].addr, VECS[i].rgb);
    end

    // R2: read-back masking and foreign ports
    ioWrite(8'hF9, 8'hFF);
    ioRead(8'hF9, rd); check("R2 mode mask", 32'(rd), 32'h3F);
    ioWrite(8'hF3, 8'hFA);
    ioRead(8'hF3, rd); check("R2 border mask", 32'(rd), 32'h02);
    ioWrite(8'hF8, 8'h00);
    ioWrite(8'h00, 8'h00);
    ioRead(8'hF9, rd); check("R2 foreign write mode", 32'(rd), 32'h3F);
    ioRead(8'hF3, rd); check("R2 foreign write border", 32'(rd), 32'h02);
    ioRead(8'hF8, rd); check("R2 foreign read", 32'(rd), 32'h00);

    // R3: set text-only, black border and adopt it
    ioWrite(8'hF9, 8'h00);
    ioWrite(8'hF3, 8'h00);
    pulseFrame();
    // now write graphics-only and a blue border without a frame pulse
    ioWrite(8'hF9, 8'h14);
    ioWrite(8'hF3, 8'h01);
    ioRead(8'hF9, rd); check("R3 pending readback", 32'(rd), 32'h14);
    runPixel("R3 old mode kept", 1'b1, 3'd6, 3'd2, 10'd7, 8'd1, 17'd647, 3'd6);
    runPixel("R3 old border kept", 1'b0, 3'd6, 3'd2, 10'd7, 8'd1, 17'd647, 3'd0);
    pulseFrame();
    runPixel("R3 new mode", 1'b1, 3'd6, 3'd2, 10'd7, 8'd1, 17'd647, 3'd2);
    runPixel("R3 new border", 1'b0, 3'd6, 3'd2, 10'd7, 8'd1, 17'd647, 3'd1);

    // R9: odd/even neighbours share a stored pixel at line start
    ioWrite(8'hF9, 8'h1C);
    pulseFrame();
    runPixel("R9 x0", 1'b1, 3'd0, 3'd5, 10'd0, 8'd199, 17'd63680, 3'd5);
    runPixel("R9 x1", 1'b1, 3'd0, 3'd5, 10'd1, 8'd199, 17'd63680, 3'd5);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule